// File: doc/BRIEF.md
# Multi-Master Hardware Lock Bank

This block holds a bank of single-bit hardware locks that several bus masters share, for example application cores and a companion controller. Every lock has its own 32-bit word. A master claims a lock by reading that word. If the read returns 0, the lock was free and now belongs to the reader. If it returns 1, someone else holds the lock and the master tries again later. The read and the set happen in the same access, so no other master can get in between. Writing 0 to the word frees the lock.

The bank also has two read-only words. One is a status word with one bit for each of the first 32 locks. The other is a configuration word that reports, as an encoded field, how many locks were built.

Each master has its own request/response port. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is held high in every cycle after reset, so the block never back-pressures a request. Exactly one cycle after acceptance, `rsp_valid` rises for one cycle with the read data (0 for writes). The response path has no back-pressure: the master must take the response in that cycle.

When several ports are accepted in the same cycle, they are applied one after another in ascending port index. Each port sees the lock state left by the lower-indexed ports before it.

Top module: `hsl_lock_bank`

## Requirements
- R1: After reset every lock is free: the lock status word reads 0, and a first read of any lock returns 0.
- R2: Lock i lives at byte offset 0x100 + 4*i. A read of a free lock returns 0 and marks the lock taken in the same access.
- R3: A read of a taken lock returns 1 and leaves the lock taken.
- R4: Writing the value 0 to a lock word frees that lock.
- R5: Writing any nonzero value to a lock word is ignored, and the lock keeps its state.
- R6: The configuration word at offset 0x000 holds the code log2(N_LOCKS)-4 in bits 31:28, with all other bits 0. N_LOCKS is one of 32, 64, 128 or 256. The default of 64 locks therefore reads 0x20000000, and 32 locks would read 0x10000000.
- R7: The lock status word at offset 0x010 has bit i set exactly when lock i is taken, for i from 0 to 31. Locks 32 and above never appear in it.
- R8: Writes to offsets 0x000 and 0x010 have no effect on any lock or on the configuration word.
- R9: Reads of unmapped or misaligned offsets return 0 and change no lock. Writes to such offsets change no lock. Unmapped offsets include those past the last lock word and any offset with bits 1:0 not equal to 0.
- R10: When several ports read the same free lock in one cycle, only the lowest-indexed port gets 0. Every other port gets 1.
- R11: `req_ready` is high for every port after reset. `rsp_valid[p]` is high in exactly the cycle after a request was accepted on port p, and low otherwise.
- R12: Requests accepted in the same cycle take effect in ascending port order. A release on a lower port followed by a read on a higher port hands the lock to the higher port. A read on a lower port followed by a release on a higher port leaves the lock free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request valid, one bit per port |
| req_ready | output | N_PORTS | Request ready, one bit per port |
| req_write | input | N_PORTS | 1 = write, 0 = read |
| req_addr | input | N_PORTS*ADDR_W | Byte offsets; port p uses bits [p*ADDR_W +: ADDR_W] |
| req_wdata | input | N_PORTS*32 | Write data; port p uses bits [p*32 +: 32] |
| rsp_valid | output | N_PORTS | Response valid, one bit per port |
| rsp_rdata | output | N_PORTS*32 | Read data; port p uses bits [p*32 +: 32] |

## Verification
A response is due exactly one clock edge after its request is accepted. A state change from a take or a release is visible to any request accepted at the next edge. The bench drives each request at a falling edge and waits for the rising edge that accepts it. It samples the response at the following falling edge, which puts it half a cycle after the output register updates. Every effect on state is then checked by a further access, issued no earlier than the cycle after the one that caused it.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  localparam int DATA_W    = 32;
  localparam int SYS_OFS   = 'h000;
  localparam int STAT_OFS  = 'h010;
  localparam int LOCK_BASE = 'h100;
  localparam int CODE_LSB  = 28;

  typedef enum logic [1:0] {
    AK_NONE,
    AK_SYS,
    AK_STAT,
    AK_LOCK
  } acc_kind_e;

  // Encoded lock count: 32 -> 1, 64 -> 2, 128 -> 3, 256 -> 4
  function automatic logic [3:0] cfg_code(input int n_locks);
    return 4'($clog2(n_locks) - 4);
  endfunction

endpackage

// File: rtl/hsl_addr_decode.sv
module hsl_addr_decode
  import hsl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int N_LOCKS = 64,
  parameter int IDX_W   = $clog2(N_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  localparam int LOCK_END = LOCK_BASE + 4 * N_LOCKS;

  logic [ADDR_W-1:0] rel;
  logic [31:0]       a32;

  always_comb begin
    a32 = 32'(addr);
    rel = addr - ADDR_W'(LOCK_BASE);
    idx = rel[IDX_W+1:2];
    if (addr[1:0] != 2'b00) begin
      kind = AK_NONE;
    end else if (a32 == 32'(SYS_OFS)) begin
      kind = AK_SYS;
    end else if (a32 == 32'(STAT_OFS)) begin
      kind = AK_STAT;
    end else if (a32 >= 32'(LOCK_BASE) && a32 < 32'(LOCK_END)) begin
      kind = AK_LOCK;
    end else begin
      kind = AK_NONE;
    end
  end

endmodule

// File: rtl/hsl_port_stage.sv
module hsl_port_stage
  import hsl_pkg::*;
#(
  parameter int N_LOCKS = 64,
  parameter int IDX_W   = $clog2(N_LOCKS)
) (
  input  logic [N_LOCKS-1:0] st_in,
  input  logic               vld,
  input  logic               wr,
  input  acc_kind_e          kind,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  sys_word,
  output logic [N_LOCKS-1:0] st_out,
  output logic [DATA_W-1:0]  rdata
);

  localparam int SHOWN = (N_LOCKS < DATA_W) ? N_LOCKS : DATA_W;

  logic [DATA_W-1:0] stat_w;

  always_comb begin
    stat_w            = '0;
    stat_w[SHOWN-1:0] = st_in[SHOWN-1:0];
  end

  // Applies this port's access on top of the state left by lower ports
  always_comb begin
    st_out = st_in;
    rdata  = '0;
    if (vld) begin
      case (kind)
        AK_SYS:  if (!wr) rdata = sys_word;
        AK_STAT: if (!wr) rdata = stat_w;
        AK_LOCK: begin
          if (wr) begin
            if (wdata == '0) st_out[idx] = 1'b0;
          end else begin
            rdata       = {{(DATA_W-1){1'b0}}, st_in[idx]};
            st_out[idx] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hsl_rsp_reg.sv
module hsl_rsp_reg
  import hsl_pkg::*;
#(
  parameter int N_PORTS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        acc,
  input  logic [N_PORTS*DATA_W-1:0] rdata_in,
  output logic [N_PORTS-1:0]        rsp_valid,
  output logic [N_PORTS*DATA_W-1:0] rsp_rdata
);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[p]                  <= 1'b0;
        rsp_rdata[p*DATA_W +: DATA_W] <= '0;
      end else begin
        rsp_valid[p]                  <= acc[p];
        rsp_rdata[p*DATA_W +: DATA_W] <= acc[p] ? rdata_in[p*DATA_W +: DATA_W] : '0;
      end
    end
  end

endmodule

// File: rtl/hsl_lock_bank.sv
module hsl_lock_bank
  import hsl_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int N_LOCKS = 64,
  parameter int ADDR_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        req_valid,
  output logic [N_PORTS-1:0]        req_ready,
  input  logic [N_PORTS-1:0]        req_write,
  input  logic [N_PORTS*ADDR_W-1:0] req_addr,
  input  logic [N_PORTS*DATA_W-1:0] req_wdata,
  output logic [N_PORTS-1:0]        rsp_valid,
  output logic [N_PORTS*DATA_W-1:0] rsp_rdata
);

  localparam int                IDX_W    = $clog2(N_LOCKS);
  localparam logic [DATA_W-1:0] SYS_WORD = DATA_W'(cfg_code(N_LOCKS)) << CODE_LSB;

  logic [N_LOCKS-1:0]               lock_q;
  logic [N_PORTS:0][N_LOCKS-1:0]    chain;
  logic [N_PORTS-1:0]               acc;
  logic [N_PORTS*DATA_W-1:0]        rdata_c;
  logic                             rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign req_ready = {N_PORTS{rdy_q}};
  assign acc       = req_valid & req_ready;
  assign chain[0]  = lock_q;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_stage
    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;

    hsl_addr_decode #(
      .ADDR_W (ADDR_W),
      .N_LOCKS(N_LOCKS),
      .IDX_W  (IDX_W)
    ) u_dec (
      .addr(req_addr[p*ADDR_W +: ADDR_W]),
      .kind(kind),
      .idx (idx)
    );

    hsl_port_stage #(
      .N_LOCKS(N_LOCKS),
      .IDX_W  (IDX_W)
    ) u_stage (
      .st_in   (chain[p]),
      .vld     (acc[p]),
      .wr      (req_write[p]),
      .kind    (kind),
      .idx     (idx),
      .wdata   (req_wdata[p*DATA_W +: DATA_W]),
      .sys_word(SYS_WORD),
      .st_out  (chain[p+1]),
      .rdata   (rdata_c[p*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= chain[N_PORTS];
  end

  hsl_rsp_reg #(
    .N_PORTS(N_PORTS)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .rdata_in (rdata_c),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/hsl_lock_bank_chk.sv
module hsl_lock_bank_chk #(
  parameter int N_PORTS = 3,
  parameter int N_LOCKS = 64,
  parameter int ADDR_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_PORTS-1:0]        req_valid,
  input logic [N_PORTS-1:0]        req_write,
  input logic [N_PORTS*ADDR_W-1:0] req_addr,
  input logic [N_PORTS*32-1:0]     req_wdata,
  input logic [N_PORTS-1:0]        rsp_valid,
  input logic [N_PORTS*32-1:0]     rsp_rdata,
  input logic [N_LOCKS-1:0]        lock_q
);

  localparam int          IDX_W   = $clog2(N_LOCKS);
  localparam int          END_OFS = 'h100 + 4 * N_LOCKS;
  localparam logic [31:0] EXP_SYS = 32'($clog2(N_LOCKS) - 4) << 28;

  logic                seen;
  logic [ADDR_W-1:0]   a0;
  logic                solo0;
  logic                p0_lock;
  logic [IDX_W-1:0]    p0_idx;
  logic                all_same_read;
  logic [N_PORTS-1:0]  zero_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_comb begin
    a0      = req_addr[ADDR_W-1:0];
    solo0   = (req_valid == N_PORTS'(1));
    p0_lock = (a0[1:0] == 2'b00) && (32'(a0) >= 32'h100) && (32'(a0) < 32'(END_OFS));
    p0_idx  = IDX_W'((32'(a0) - 32'h100) >> 2);
    all_same_read = p0_lock;
    for (int p = 0; p < N_PORTS; p++) begin
      zero_vec[p] = (rsp_rdata[p*32 +: 32] == 32'd0);
      if (!req_valid[p] || req_write[p] || req_addr[p*ADDR_W +: ADDR_W] != a0)
        all_same_read = 1'b0;
    end
  end

  p_reset_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> lock_q == '0);

  p_read_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(solo0 && !req_write[0] && p0_lock && !lock_q[p0_idx])
    |-> lock_q[$past(p0_idx)] && rsp_rdata[31:0] == 32'd0);

  p_taken_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(solo0 && !req_write[0] && p0_lock && lock_q[p0_idx])
    |-> lock_q[$past(p0_idx)] && rsp_rdata[31:0] == 32'd1);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(solo0 && req_write[0] && p0_lock && req_wdata[31:0] == 32'd0)
    |-> !lock_q[$past(p0_idx)]);

  p_nonzero_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(solo0 && req_write[0] && req_wdata[31:0] != 32'd0)
    |-> lock_q == $past(lock_q));

  p_sys_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(solo0 && !req_write[0] && a0 == ADDR_W'(0))
    |-> rsp_rdata[31:0] == EXP_SYS);

  p_status_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(solo0 && !req_write[0] && a0 == ADDR_W'('h10))
    |-> rsp_rdata[31:0] == $past(lock_q[31:0]));

  p_one_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(all_same_read) |-> $onehot0(zero_vec));

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> rsp_valid == $past(req_valid));

endmodule

bind hsl_lock_bank hsl_lock_bank_chk #(
  .N_PORTS(N_PORTS),
  .N_LOCKS(N_LOCKS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .lock_q   (lock_q)
);

// File: tb/sim_hsl_lock_bank.sv
`timescale 1ns/1ps
module sim_hsl_lock_bank;

  localparam int NP = 3;
  localparam int NL = 64;
  localparam int AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     req_valid = '0;
  logic [NP-1:0]     req_ready;
  logic [NP-1:0]     req_write = '0;
  logic [NP*AW-1:0]  req_addr = '0;
  logic [NP*32-1:0]  req_wdata = '0;
  logic [NP-1:0]     rsp_valid;
  logic [NP*32-1:0]  rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0]   got [NP];
  logic [NP-1:0] got_v;
  logic [31:0]   r;

  always #2.5 clk = ~clk;

  hsl_lock_bank #(.N_PORTS(NP), .N_LOCKS(NL), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [11:0] lk(input int i);
    return 12'('h100 + 4 * i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic multi(input logic [NP-1:0] v, input logic [NP-1:0] w,
                       input logic [11:0] a0, input logic [11:0] a1, input logic [11:0] a2,
                       input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
    @(negedge clk);
    req_valid = v;
    req_write = w;
    req_addr  = {a2, a1, a0};
    req_wdata = {d2, d1, d0};
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    got_v = rsp_valid;
    for (int p = 0; p < NP; p++) got[p] = rsp_rdata[p*32 +: 32];
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    multi(3'b001, 3'b000, a, 12'h0, 12'h0, 32'h0, 32'h0, 32'h0);
    d = got[0];
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    multi(3'b001, 3'b001, a, 12'h0, 12'h0, d, 32'h0, 32'h0);
  endtask

  task automatic t_reset;
    chk(rsp_valid == '0, "R11 no response after reset", 32'(rsp_valid), 32'h0);
    chk(req_ready == '1, "R11 ready high", 32'(req_ready), 32'h7);
    rd(12'h010, r); chk(r == 32'h0, "R1 status after reset", r, 32'h0);
    rd(12'h000, r); chk(r == 32'h2000_0000, "R6 config word", r, 32'h2000_0000);
    rd(lk(3), r);   chk(r == 32'h0, "R1 first read free", r, 32'h0);
    wr(lk(3), 32'h0);
  endtask

  task automatic t_take;
    rd(lk(5), r);   chk(r == 32'h0, "R2 take free lock", r, 32'h0);
    rd(12'h010, r); chk(r == 32'h20, "R2 R7 status bit 5", r, 32'h20);
    rd(lk(5), r);   chk(r == 32'h1, "R3 read taken lock", r, 32'h1);
    rd(12'h010, r); chk(r == 32'h20, "R3 still taken", r, 32'h20);
  endtask

  task automatic t_release;
    wr(lk(5), 32'h0);
    rd(12'h010, r); chk(r == 32'h0, "R4 release clears", r, 32'h0);
    rd(lk(5), r);   chk(r == 32'h0, "R4 retake after release", r, 32'h0);
  endtask

  task automatic t_nonzero;
    wr(lk(5), 32'h1);
    wr(lk(5), 32'h8000_0000);
    rd(lk(5), r);   chk(r == 32'h1, "R5 nonzero write ignored", r, 32'h1);
    wr(lk(5), 32'h0);
  endtask

  task automatic t_high;
    rd(lk(40), r);  chk(r == 32'h0, "R2 take lock 40", r, 32'h0);
    rd(lk(NL-1), r); chk(r == 32'h0, "R2 take last lock", r, 32'h0);
    rd(12'h010, r); chk(r == 32'h0, "R7 high locks hidden", r, 32'h0);
    rd(lk(40), r);  chk(r == 32'h1, "R3 lock 40 held", r, 32'h1);
    rd(lk(31), r);
    rd(12'h010, r); chk(r == 32'h8000_0000, "R7 bit 31", r, 32'h8000_0000);
    wr(lk(40), 32'h0); wr(lk(NL-1), 32'h0); wr(lk(31), 32'h0);
    rd(lk(NL-1), r); chk(r == 32'h0, "R4 last lock freed", r, 32'h0);
    wr(lk(NL-1), 32'h0);
  endtask

  task automatic t_ro_words;
    rd(lk(2), r);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0);
    rd(12'h010, r); chk(r == 32'h4, "R8 status write ignored", r, 32'h4);
    rd(12'h000, r); chk(r == 32'h2000_0000, "R8 config write ignored", r, 32'h2000_0000);
    wr(lk(2), 32'h0);
  endtask

  task automatic t_unmapped;
    rd(12'h200, r); chk(r == 32'h0, "R9 past last lock reads 0", r, 32'h0);
    rd(12'h101, r); chk(r == 32'h0, "R9 misaligned reads 0", r, 32'h0);
    rd(12'h044, r); chk(r == 32'h0, "R9 hole reads 0", r, 32'h0);
    rd(12'h010, r); chk(r == 32'h0, "R9 reads took nothing", r, 32'h0);
    rd(lk(1), r);
    wr(12'h105, 32'h0);
    rd(12'h010, r); chk(r == 32'h2, "R9 misaligned write ignored", r, 32'h2);
    wr(lk(1), 32'h0);
  endtask

  task automatic t_contend;
    multi(3'b111, 3'b000, lk(7), lk(7), lk(7), 0, 0, 0);
    chk(got[0] == 32'h0, "R10 port 0 wins", got[0], 32'h0);
    chk(got[1] == 32'h1, "R10 port 1 loses", got[1], 32'h1);
    chk(got[2] == 32'h1, "R10 port 2 loses", got[2], 32'h1);
    wr(lk(7), 32'h0);
    multi(3'b110, 3'b000, 12'h0, lk(7), lk(7), 0, 0, 0);
    chk(got[1] == 32'h0 && got[2] == 32'h1, "R10 port 1 beats port 2",
        {got[1][15:0], got[2][15:0]}, 32'h0000_0001);
    wr(lk(7), 32'h0);
  endtask

  task automatic t_order;
    rd(lk(9), r);
    multi(3'b011, 3'b001, lk(9), lk(9), 12'h0, 0, 0, 0);
    chk(got[1] == 32'h0, "R12 release then take", got[1], 32'h0);
    rd(12'h010, r); chk(r == 32'h200, "R12 lock 9 handed over", r, 32'h200);
    multi(3'b011, 3'b010, lk(9), lk(9), 12'h0, 0, 0, 0);
    chk(got[0] == 32'h1, "R12 read before release", got[0], 32'h1);
    rd(12'h010, r); chk(r == 32'h0, "R12 lock 9 ends free", r, 32'h0);
  endtask

  task automatic t_handshake;
    multi(3'b101, 3'b000, 12'h010, 12'h0, 12'h000, 0, 0, 0);
    chk(got_v == 3'b101, "R11 valid on requesting ports", 32'(got_v), 32'h5);
    chk(got[2] == 32'h2000_0000, "R6 config on port 2", got[2], 32'h2000_0000);
    @(negedge clk);
    chk(rsp_valid == '0, "R11 valid lasts one cycle", 32'(rsp_valid), 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_take();
    t_release();
    t_nonzero();
    t_high();
    t_ro_words();
    t_unmapped();
    t_contend();
    t_order();
    t_handshake();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule